// File: doc/BRIEF.md
# FM Channel Time-Division Stereo Multiplexer

This block turns six parallel signed 14-bit synthesis results into a single time-division stereo stream. Nothing is summed. On every clock-enable pulse the block emits one channel: the upper nine bits of that channel's result go onto the left output, the right output, both or neither, according to that channel's two pan enable bits. The emitted channel index is reported alongside the sample. Successive pulses step through the channels in a fixed, repeating order.

An 8-bit unsigned sample register can stand in for the last channel. While the substitution flag is high, the last channel's slot carries that sample. The sample is first made signed by flipping its top bit, then scaled up to the 9-bit output format by appending a zero LSB. The other slots are not affected. Downstream, a converter or a bench model reconstructs the audio from the slot-tagged stream.

Top module: `fm_slot_mux`

## Requirements
- R1: While reset is low, and after its release until the first clock-enable pulse, `left_out` and `right_out` are zero and `slot_out` is 0.
- R2: Each pulse of `slot_ce` emits exactly one channel. The first pulse after reset emits channel 0. Each further pulse emits the next index, and channel 5 is followed by channel 0. `slot_out` carries the index of the emitted channel.
- R3: For channel k (k = 0 to 5), the emitted sample is bits [13:5] of `ch_data[k*14 +: 14]`. This equals the signed 14-bit value shifted right arithmetically by five places.
- R4: Bit 1 of `pan_lr[k*2 +: 2]` enables the left side of channel k. When it is set, `left_out` shows the emitted sample. When it is clear, `left_out` is zero for that slot.
- R5: Bit 0 of `pan_lr[k*2 +: 2]` enables the right side of channel k. When it is set, `right_out` shows the emitted sample. When it is clear, `right_out` is zero for that slot.
- R6: While `dac_en` is 1, the channel-5 slot carries the converted DAC sample instead of the channel-5 synthesis result. The pan bits of channel 5 still apply.
- R7: The converted DAC sample for an unsigned byte d is the 9-bit two's-complement value 2*(d-128). So 0x80 gives 0, 0x00 gives -256 and 0xFF gives 254.
- R8: `dac_en` has no effect on the samples emitted in slots 0 to 4.
- R9: When `slot_ce` is low, `left_out`, `right_out` and `slot_out` keep their values, even if the data, pan or DAC inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_ce | input | 1 | Slot advance strobe; one channel is emitted per pulse |
| ch_data | input | 84 | Six signed 14-bit channel results; channel k at [k*14 +: 14] |
| pan_lr | input | 12 | Per-channel pan enables; channel k at [k*2 +: 2], bit 1 left, bit 0 right |
| dac_value | input | 8 | Unsigned DAC sample |
| dac_en | input | 1 | Substitute the DAC sample for channel 5 |
| left_out | output | 9 | Left sample of the emitted slot, signed |
| right_out | output | 9 | Right sample of the emitted slot, signed |
| slot_out | output | 3 | Index of the emitted channel |

## Verification
Every output comes from a single register stage. The sample, both sides and the slot index therefore take the values of the inputs and the internal slot position present at the rising edge where `slot_ce` is high, and become visible just after that edge. The bench sets all inputs on the falling edge, raises `slot_ce` for one edge only, and compares one time unit after that edge against a slot position it counts on its own. For the hold requirement, the bench first changes every input, then runs idle cycles, and samples again after those edges.

// File: rtl/fm_slot_mux_pkg.sv
package fm_slot_mux_pkg;

   // Width of the per-channel pan field and the meaning of its bits.
   localparam int PAN_W       = 2;
   localparam int PAN_LEFT_B  = 1;
   localparam int PAN_RIGHT_B = 0;

   // Side gating of the slot currently selected.
   typedef struct packed {
      logic left;
      logic right;
   } pan_sel_t;

endpackage

// File: rtl/fm_slot_counter.sv
module fm_slot_counter #(
   parameter int NUM_CH = 6,
   parameter int SLOT_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [SLOT_W-1:0] slot
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CH - 1);

   if (NUM_CH < 2) begin : g_bad_count
      $error("fm_slot_counter: NUM_CH must be at least 2");
   end
   if ((1 << SLOT_W) < NUM_CH) begin : g_bad_width
      $error("fm_slot_counter: SLOT_W too narrow for NUM_CH");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot <= '0;
      end else if (adv) begin
         if (slot == LAST) slot <= '0;
         else              slot <= slot + 1'b1;
      end
   end

   // R2: position never leaves the legal range
   p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= LAST);

   // R2: last channel is followed by channel 0
   p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && slot == LAST) |=> slot == '0);

   // R2: otherwise one step per pulse
   p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && slot != LAST) |=> slot == $past(slot) + 1'b1);

   // R9: no pulse, no movement
   p_slot_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(slot));

endmodule

// File: rtl/fm_dac_format.sv
module fm_dac_format #(
   parameter int DAC_W = 8,
   parameter int OUT_W = 9
) (
   input  logic [DAC_W-1:0] dac_value,
   output logic [OUT_W-1:0] sample
);

   if (DAC_W < 2) begin : g_bad_dac
      $error("fm_dac_format: DAC_W must be at least 2");
   end

   // Offset-binary to two's complement: flip the top bit.
   logic [DAC_W-1:0] signed_val;
   assign signed_val = {~dac_value[DAC_W-1], dac_value[DAC_W-2:0]};

   if (OUT_W > DAC_W) begin : g_widen
      assign sample = {signed_val, {(OUT_W-DAC_W){1'b0}}};
   end else if (OUT_W == DAC_W) begin : g_same
      assign sample = signed_val;
   end else begin : g_narrow
      assign sample = signed_val[DAC_W-1 -: OUT_W];
   end

endmodule

// File: rtl/fm_lane_select.sv
module fm_lane_select
   import fm_slot_mux_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int IN_W   = 14,
   parameter int OUT_W  = 9,
   parameter int SLOT_W = $clog2(NUM_CH),
   parameter int DAC_CH = NUM_CH - 1
) (
   input  logic [NUM_CH*IN_W-1:0]  ch_data,
   input  logic [NUM_CH*PAN_W-1:0] pan_lr,
   input  logic [OUT_W-1:0]        dac_sample,
   input  logic                    dac_en,
   input  logic [SLOT_W-1:0]       slot,
   output logic [OUT_W-1:0]        sample,
   output pan_sel_t                side
);

   if (OUT_W > IN_W) begin : g_bad_trunc
      $error("fm_lane_select: OUT_W may not exceed IN_W");
   end
   if (DAC_CH < 0 || DAC_CH >= NUM_CH) begin : g_bad_dac_ch
      $error("fm_lane_select: DAC_CH out of range");
   end

   logic [OUT_W-1:0] lane     [NUM_CH];
   pan_sel_t         lane_pan [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      logic [OUT_W-1:0] trunc;
      assign trunc = ch_data[c*IN_W + IN_W - 1 -: OUT_W];

      if (c == DAC_CH) begin : g_dac_lane
         assign lane[c] = dac_en ? dac_sample : trunc;
      end else begin : g_fm_lane
         assign lane[c] = trunc;
      end

      assign lane_pan[c].left  = pan_lr[c*PAN_W + PAN_LEFT_B];
      assign lane_pan[c].right = pan_lr[c*PAN_W + PAN_RIGHT_B];
   end

   always_comb begin
      sample = '0;
      side   = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (slot == SLOT_W'(i)) begin
            sample = lane[i];
            side   = lane_pan[i];
         end
      end
   end

endmodule

// File: rtl/fm_slot_mux.sv
module fm_slot_mux
   import fm_slot_mux_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int IN_W   = 14,
   parameter int OUT_W  = 9,
   parameter int DAC_W  = 8,
   parameter int DAC_CH = NUM_CH - 1,
   localparam int SLOT_W = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    slot_ce,
   input  logic [NUM_CH*IN_W-1:0]  ch_data,
   input  logic [NUM_CH*PAN_W-1:0] pan_lr,
   input  logic [DAC_W-1:0]        dac_value,
   input  logic                    dac_en,
   output logic [OUT_W-1:0]        left_out,
   output logic [OUT_W-1:0]        right_out,
   output logic [SLOT_W-1:0]       slot_out
);

   logic [SLOT_W-1:0] cur_slot;
   logic [OUT_W-1:0]  dac_sample;
   logic [OUT_W-1:0]  sel_sample;
   pan_sel_t          sel_side;

   fm_slot_counter #(
      .NUM_CH (NUM_CH),
      .SLOT_W (SLOT_W)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (slot_ce),
      .slot  (cur_slot)
   );

   fm_dac_format #(
      .DAC_W (DAC_W),
      .OUT_W (OUT_W)
   ) u_dac_fmt (
      .dac_value (dac_value),
      .sample    (dac_sample)
   );

   fm_lane_select #(
      .NUM_CH (NUM_CH),
      .IN_W   (IN_W),
      .OUT_W  (OUT_W),
      .SLOT_W (SLOT_W),
      .DAC_CH (DAC_CH)
   ) u_lanes (
      .ch_data    (ch_data),
      .pan_lr     (pan_lr),
      .dac_sample (dac_sample),
      .dac_en     (dac_en),
      .slot       (cur_slot),
      .sample     (sel_sample),
      .side       (sel_side)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_out  <= '0;
         right_out <= '0;
         slot_out  <= '0;
      end else if (slot_ce) begin
         left_out  <= sel_side.left  ? sel_sample : '0;
         right_out <= sel_side.right ? sel_sample : '0;
         slot_out  <= cur_slot;
      end
   end

   // R2: the index reported is the position that was emitted
   p_slot_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_ce |=> slot_out == $past(cur_slot));

   // R9: outputs frozen between pulses
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_ce |=> ($stable(left_out) && $stable(right_out) && $stable(slot_out)));

   // R4: a disabled left side emits zero
   p_left_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_ce && !pan_lr[cur_slot*PAN_W + PAN_LEFT_B]) |=> left_out == '0);

   // R5: a disabled right side emits zero
   p_right_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_ce && !pan_lr[cur_slot*PAN_W + PAN_RIGHT_B]) |=> right_out == '0);

   // R5: both sides on carry the same sample
   p_both_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_ce && pan_lr[cur_slot*PAN_W + PAN_LEFT_B]
               && pan_lr[cur_slot*PAN_W + PAN_RIGHT_B]) |=> left_out == right_out);

   if (OUT_W > DAC_W) begin : g_dac_lsb_chk
      // R7: a widened DAC sample has zero low bits
      p_dac_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_ce && dac_en && cur_slot == SLOT_W'(DAC_CH)
                  && pan_lr[DAC_CH*PAN_W + PAN_LEFT_B])
         |=> left_out[OUT_W-DAC_W-1:0] == '0);
   end

endmodule

// File: tb/fm_slot_mux_tb.sv
module fm_slot_mux_tb;

   localparam int NCH = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot_ce = 1'b0;
   logic [83:0] ch_data = '0;
   logic [11:0] pan_lr = '0;
   logic [7:0]  dac_value = '0;
   logic        dac_en = 1'b0;
   logic [8:0]  left_out, right_out;
   logic [2:0]  slot_out;

   int chv [NCH];
   logic [1:0] panv [NCH];
   int checks = 0;
   int errors = 0;
   int exp_slot = 0;

   always #5ns clk = ~clk;

   fm_slot_mux u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_ce   (slot_ce),
      .ch_data   (ch_data),
      .pan_lr    (pan_lr),
      .dac_value (dac_value),
      .dac_en    (dac_en),
      .left_out  (left_out),
      .right_out (right_out),
      .slot_out  (slot_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive();
      for (int c = 0; c < NCH; c++) begin
         ch_data[c*14 +: 14] = 14'(chv[c]);
         pan_lr[c*2 +: 2]    = panv[c];
      end
   endtask

   function automatic int exp_sample(int s);
      if (s == NCH-1 && dac_en) return (int'(dac_value) - 128) * 2;
      return chv[s] >>> 5;
   endfunction

   function automatic int s9(logic [8:0] v);
      return int'($signed(v));
   endfunction

   // One pulse, then compare; only_slot < 0 means compare every slot.
   task automatic pulse(input int only_slot);
      int e;
      @(negedge clk);
      drive();
      slot_ce = 1'b1;
      @(posedge clk);
      #1;
      slot_ce = 1'b0;
      if (only_slot < 0 || only_slot == exp_slot) begin
         e = exp_sample(exp_slot);
         chk("R2 slot index", int'(slot_out), exp_slot);
         if (exp_slot == NCH-1 && dac_en) begin
            chk("R6/R7 left DAC", s9(left_out),  panv[exp_slot][1] ? e : 0);
            chk("R6/R7 right DAC", s9(right_out), panv[exp_slot][0] ? e : 0);
         end else if (dac_en) begin
            chk("R8 R4 left", s9(left_out),  panv[exp_slot][1] ? e : 0);
            chk("R8 R5 right", s9(right_out), panv[exp_slot][0] ? e : 0);
         end else begin
            chk("R3 R4 left", s9(left_out),  panv[exp_slot][1] ? e : 0);
            chk("R3 R5 right", s9(right_out), panv[exp_slot][0] ? e : 0);
         end
      end
      exp_slot = (exp_slot == NCH-1) ? 0 : exp_slot + 1;
   endtask

   initial begin
      #1ms;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [8:0] hl, hr;
      logic [2:0] hs;
      for (int c = 0; c < NCH; c++) begin
         chv[c] = 0;
         panv[c] = 2'b11;
      end
      ch_data = {84{1'b1}};
      pan_lr = '1;
      repeat (3) @(posedge clk);
      #1;
      // R1 during reset
      chk("R1 left in reset", int'(left_out), 0);
      chk("R1 right in reset", int'(right_out), 0);
      chk("R1 slot in reset", int'(slot_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 left after release", int'(left_out), 0);
      chk("R1 slot after release", int'(slot_out), 0);

      // Sweep pan patterns, data patterns and DAC mode
      for (int mode = 0; mode < 3; mode++) begin
         for (int t = 0; t < 64; t++) begin
            dac_en = (mode != 0);
            dac_value = 8'((t * 37 + mode * 91) & 8'hFF);
            for (int c = 0; c < NCH; c++) begin
               int v;
               v = ((t * 1237 + c * 2903 + mode * 517) & 16'h3FFF) - 8192;
               if (t == 1) v = (c % 2 == 0) ? -8192 : 8191;
               if (t == 2) v = (c % 2 == 0) ? -1 : 31;
               if (t == 3) v = (c % 2 == 0) ? 32 : -33;
               chv[c]  = v;
               panv[c] = {t[c], t[(c + 1) % NCH]};
            end
            for (int k = 0; k < NCH; k++) pulse(-1);
         end
      end

      // R7 exhaustive DAC byte sweep with both sides on for channel 5
      dac_en = 1'b1;
      panv[NCH-1] = 2'b11;
      for (int d = 0; d < 256; d++) begin
         dac_value = 8'(d);
         for (int k = 0; k < NCH; k++) pulse(NCH-1);
      end

      // R7 named corners
      dac_value = 8'h80;
      for (int k = 0; k < NCH; k++) pulse(NCH-1);
      chk("R7 0x80 gives 0", s9(left_out), 0);
      dac_value = 8'h00;
      for (int k = 0; k < NCH; k++) pulse(NCH-1);
      chk("R7 0x00 gives -256", s9(left_out), -256);
      dac_value = 8'hFF;
      for (int k = 0; k < NCH; k++) pulse(NCH-1);
      chk("R7 0xFF gives 254", s9(right_out), 254);

      // R9 hold without pulse while all inputs change
      pulse(-1);
      hl = left_out;
      hr = right_out;
      hs = slot_out;
      @(negedge clk);
      ch_data = ~ch_data;
      pan_lr = ~pan_lr;
      dac_value = ~dac_value;
      dac_en = ~dac_en;
      repeat (4) @(posedge clk);
      #1;
      chk("R9 left held", int'(left_out), int'(hl));
      chk("R9 right held", int'(right_out), int'(hr));
      chk("R9 slot held", int'(slot_out), int'(hs));
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         chv[c] = 100 * c - 4000;
         panv[c] = 2'b10;
      end
      dac_en = 1'b0;
      // R2 resumes at the next position after idle time
      pulse(-1);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule